// File: doc/BRIEF.md
# Watch Timer with Interval Prescaler

This block produces two periodic event pulses from a slow watch clock. The watch clock comes from one of two single-cycle strobes in the system clock domain: either a main-clock strobe divided down by 128, or a strobe taken from a 32.768 kHz subsystem oscillator. Each watch-clock strobe advances a 9-bit prescaler. The prescaler's wrap advances a 5-bit counter. A watch event pulse is taken from the counter, or from a low prescaler bit in the fast-feed mode. An interval event pulse is taken from one of six prescaler bits.

An 8-bit control register selects the mode, the watch period and the interval tap. It also holds a run bit for the prescaler and a run bit for the counter. When a run bit is cleared, that stage stops and is held at zero. Software can write the whole register, or change any one bit and leave the others as they are. Every event pulse lasts one system-clock cycle and appears in the cycle after the strobe that takes its tap bit from 0 to 1. The whole block runs in one clock domain.

Top module: `watch_tmr`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00 and both event outputs are low.
- R2: A whole-register write stores data bits 6:0. Bit 7 always reads as 0. Field layout: bit 0 is fast feed, bit 1 is counter run, bit 2 is prescaler run, bit 3 is the short watch period, and bits 6:4 are the interval code.
- R3: A single-bit write sets the addressed bit to `wr_data[0]` and leaves every other bit unchanged. A single-bit write to index 7 has no effect.
- R4: With `src_sub`=0, the watch clock gives one strobe per 128 `main_tick` strobes, and `sub_tick` is ignored. With `src_sub`=1, each `sub_tick` is one strobe, and `main_tick` is ignored.
- R5: While the prescaler run bit is 0, the prescaler is held at zero and no pulse derived from it occurs. When counting restarts, it begins again from zero.
- R6: While the counter run bit is 0, the counter is held at zero. While the bit is 1, the counter advances once per prescaler wrap, which occurs every 512 watch strobes.
- R7: In fast feed (bit 0 = 1), the first watch pulse comes 16 watch strobes after the stages leave the cleared state. Later pulses follow every 32 strobes.
- R8: In normal mode with bit 3 = 0, the first watch pulse comes at strobe 8192. Later pulses follow every 16384 strobes.
- R9: In normal mode with bit 3 = 1, the first watch pulse comes at strobe 4096. Later pulses follow every 8192 strobes.
- R10: Interval codes 0 to 5 give a first interval pulse at strobe 2^(code+3). Later pulses follow every 2^(code+4) strobes.
- R11: Interval codes 6 and 7 produce no interval pulse.
- R12: Each event pulse is exactly one system-clock cycle wide. The watch pulse and the interval pulse can be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sub | input | 1 | Watch clock source: 0 = main strobe divided by 128, 1 = subsystem strobe |
| main_tick | input | 1 | Single-cycle strobe at the main clock rate |
| sub_tick | input | 1 | Single-cycle strobe at the subsystem clock rate |
| wr_en | input | 1 | Register write request |
| wr_all | input | 1 | 1 = whole-register write, 0 = single-bit write |
| wr_idx | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Write data; for a single-bit write, bit 0 is the value |
| rd_data | output | 8 | Current register contents |
| watch_flag | output | 1 | Watch event pulse |
| intv_flag | output | 1 | Interval event pulse |

## Verification
The watch pulse and the interval pulse can fall in the same cycle. This happens when fast feed is combined with interval code 1, because then both taps are prescaler bit 4 and both rise on the same strobe. The bench sets up this case and counts the cycles in which both outputs are high at once. That count must equal each flag's own pulse count, and the first pulse must come at strobe 16, so neither pulse may be lost, split or delayed when they coincide.

// File: rtl/wt_pkg.sv
// Shared parameters and the control register layout for the watch timer.
// Assumes the field order below; the bench and the top decode it.
package wt_pkg;
    localparam int PRESC_W    = 9;   // prescaler width
    localparam int CNT_W      = 5;   // watch counter width
    localparam int DIV_LOG2   = 7;   // main strobe divide ratio, log2
    localparam int FAST_LOG2  = 5;   // fast feed period, log2
    localparam int INTV_BASE  = 4;   // shortest interval period, log2
    localparam int INTV_CODES = 6;   // number of legal interval codes
    localparam int SEL_W      = 3;   // interval code width

    typedef struct packed {
        logic             rsv;          // bit 7, always 0
        logic [SEL_W-1:0] intv_sel;     // bits 6:4
        logic             watch_short;  // bit 3
        logic             presc_run;    // bit 2
        logic             cnt_run;      // bit 1
        logic             fast_feed;    // bit 0
    } wt_ctrl_t;
endpackage

// File: rtl/wt_ctrl_reg.sv
// Control register. Whole-register or single-bit writes; bit 7 is held at 0.
// Assumes wr_* inputs are sampled on the rising clock edge.
module wt_ctrl_reg
    import wt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_all,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output wt_ctrl_t   ctrl
);
    logic [7:0] reg_q;
    logic [7:0] reg_d;

    // Next value: merge the write into the current contents, force bit 7 low.
    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            if (wr_all) begin
                reg_d = wr_data;
            end else begin
                reg_d[wr_idx] = wr_data[0];
            end
        end
        reg_d[7] = 1'b0;
    end

    // Register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign ctrl = wt_ctrl_t'(reg_q);

    assert_byte_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_all) |=> (reg_q == {1'b0, $past(wr_data[6:0])}));

    assert_bit_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_all && wr_idx != 3'd7) |=> (reg_q[$past(wr_idx)] == $past(wr_data[0])));

    assert_bit7_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_all && wr_idx == 3'd7) |=> $stable(reg_q));
endmodule

// File: rtl/wt_clk_sel.sv
// Watch clock source: picks the divided main strobe or the subsystem strobe.
// Assumes both inputs are single-cycle strobes in the clk domain.
module wt_clk_sel #(
    parameter int DIV_LOG2 = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sub,
    input  logic main_tick,
    input  logic sub_tick,
    output logic fw_tick
);
    logic div_done;

    generate
        if (DIV_LOG2 > 0) begin : g_div
            logic [DIV_LOG2-1:0] div_q;
            // Free-running divider advanced by main strobes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (main_tick) begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign div_done = main_tick && (&div_q);

            assert_div_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!src_sub && fw_tick) |=> (src_sub || !fw_tick));
        end else begin : g_nodiv
            assign div_done = main_tick;
        end
    endgenerate

    // Source selection.
    assign fw_tick = src_sub ? sub_tick : div_done;

    assert_main_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sub && fw_tick) |-> main_tick);
endmodule

// File: rtl/wt_prescaler.sv
// Prescaler with run/clear control, wrap strobe, fast-feed tap and a selectable
// interval tap. Assumes fw_tick is a single-cycle strobe.
module wt_prescaler
    import wt_pkg::*;
#(
    parameter int W      = PRESC_W,
    parameter int FAST_B = FAST_LOG2 - 1,
    parameter int BASE_B = INTV_BASE - 1,
    parameter int CODES  = INTV_CODES,
    parameter int SW     = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          fw_tick,
    input  logic [SW-1:0] intv_sel,
    output logic          wrap,
    output logic          fast_tap,
    output logic          intv_tap
);
    localparam int NSEL = 1 << SW;

    logic [W-1:0]    presc_q;
    logic [NSEL-1:0] tap_vec;

    // Count watch strobes while running; hold cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            presc_q <= '0;
        end else if (fw_tick) begin
            presc_q <= presc_q + 1'b1;
        end
    end

    assign wrap     = en && fw_tick && (&presc_q);
    assign fast_tap = presc_q[FAST_B];

    // Interval tap table: legal codes pick a prescaler bit, the rest give 0.
    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_tap
            if (g < CODES) begin : g_legal
                assign tap_vec[g] = presc_q[g + BASE_B];
            end else begin : g_bad
                assign tap_vec[g] = 1'b0;
            end
        end
    endgenerate

    assign intv_tap = tap_vec[intv_sel];

    assert_hold_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (presc_q == '0));

    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fw_tick) |=> $stable(presc_q));
endmodule

// File: rtl/wt_counter.sv
// Watch counter advanced by prescaler wraps, with run/clear control.
// Exposes its top bit (long period) and next bit (short period).
module wt_counter
    import wt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    output logic tap_long,
    output logic tap_short
);
    logic [W-1:0] cnt_q;

    // Count prescaler wraps while running; hold cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tap_long  = cnt_q[W-1];
    assign tap_short = cnt_q[W-2];

    assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));

    assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/wt_edge_pulse.sv
// Rising-edge detector: one-cycle pulse when the tap goes from 0 to 1.
// Assumes tap is a registered signal in the clk domain.
module wt_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic tap,
    output logic pulse
);
    logic tap_q;

    // Remember the previous tap level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= 1'b0;
        end else begin
            tap_q <= tap;
        end
    end

    assign pulse = tap && !tap_q;

    assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/watch_tmr.sv
// Watch timer top: control register, clock source, prescaler, counter and the
// two event pulse generators. Single clock domain, synchronous active-low reset.
module watch_tmr
    import wt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_sub,
    input  logic       main_tick,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic       wr_all,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       watch_flag,
    output logic       intv_flag
);
    wt_ctrl_t ctrl;
    logic     fw_tick;
    logic     wrap;
    logic     fast_tap;
    logic     intv_tap;
    logic     tap_long;
    logic     tap_short;
    logic     watch_tap;

    wt_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_all  (wr_all),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    wt_clk_sel #(.DIV_LOG2(DIV_LOG2)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sub   (src_sub),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .fw_tick   (fw_tick)
    );

    wt_prescaler u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.presc_run),
        .fw_tick  (fw_tick),
        .intv_sel (ctrl.intv_sel),
        .wrap     (wrap),
        .fast_tap (fast_tap),
        .intv_tap (intv_tap)
    );

    wt_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.cnt_run),
        .step      (wrap),
        .tap_long  (tap_long),
        .tap_short (tap_short)
    );

    // Watch tap: fast feed taps the prescaler, normal mode taps the counter.
    always_comb begin
        if (ctrl.fast_feed) begin
            watch_tap = fast_tap;
        end else if (ctrl.watch_short) begin
            watch_tap = tap_short;
        end else begin
            watch_tap = tap_long;
        end
    end

    wt_edge_pulse u_watch_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .tap   (watch_tap),
        .pulse (watch_flag)
    );

    wt_edge_pulse u_intv_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .tap   (intv_tap),
        .pulse (intv_flag)
    );

    assign rd_data = ctrl;

    assert_no_bad_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ctrl.intv_sel) >= INTV_CODES) |-> !intv_flag);

    assert_stopped_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.presc_run && $past(!ctrl.presc_run)) |-> !intv_flag);
endmodule

// File: tb/watch_tmr_tb.sv
// Directed bench for the watch timer: one task per scenario.
module watch_tmr_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sub = 1'b1;
    logic       main_tick = 1'b0;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_all = 1'b0;
    logic [2:0] wr_idx = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       watch_flag;
    logic       intv_flag;

    int checks = 0;
    int errors = 0;
    int t, w_n, w_first, w_last, i_n, i_first, i_last, both_n;
    int cyc = 0;
    bit done = 1'b0;

    watch_tmr dut_i (
        .clk(clk), .rst_n(rst_n), .src_sub(src_sub), .main_tick(main_tick),
        .sub_tick(sub_tick), .wr_en(wr_en), .wr_all(wr_all), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_data(rd_data), .watch_flag(watch_flag),
        .intv_flag(intv_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_stats();
        t = 0; w_n = 0; w_first = -1; w_last = -1;
        i_n = 0; i_first = -1; i_last = -1; both_n = 0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        wr_en = 1'b1; wr_all = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_bit(input int idx, input logic v);
        wr_en = 1'b1; wr_all = 1'b0; wr_idx = 3'(idx); wr_data = {7'd0, v};
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Clear both stages, then load the configuration and zero the statistics.
    task automatic restart(input logic [7:0] cfg);
        wr_byte(cfg & 8'hF9);
        @(posedge clk); @(negedge clk);
        wr_byte(cfg);
        clr_stats();
    endtask

    // Drive n cycles of strobes and record pulse positions by strobe count.
    task automatic run(input int n, input logic m, input logic s);
        for (int k = 0; k < n; k++) begin
            main_tick = m; sub_tick = s;
            @(posedge clk);
            t++;
            @(negedge clk);
            if (watch_flag) begin
                w_n++; if (w_first < 0) w_first = t; w_last = t;
            end
            if (intv_flag) begin
                i_n++; if (i_first < 0) i_first = t; i_last = t;
            end
            if (watch_flag && intv_flag) both_n++;
        end
        main_tick = 1'b0; sub_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk(rd_data, 0, "R1 reg after reset");
        chk(watch_flag, 0, "R1 watch low after reset");
        chk(intv_flag, 0, "R1 intv low after reset");
    endtask

    task automatic t_byte_write();
        wr_byte(8'hFF);
        chk(rd_data, 8'h7F, "R2 byte write 0xFF");
        wr_byte(8'hA5);
        chk(rd_data, 8'h25, "R2 byte write 0xA5");
        wr_byte(8'h00);
    endtask

    task automatic t_bit_write();
        wr_byte(8'h41);
        wr_bit(3, 1'b1);
        chk(rd_data, 8'h49, "R3 set bit 3");
        wr_bit(7, 1'b1);
        chk(rd_data, 8'h49, "R3 bit 7 write ignored");
        wr_bit(0, 1'b0);
        chk(rd_data, 8'h48, "R3 clear bit 0");
        wr_byte(8'h00);
    endtask

    task automatic t_main_src();
        src_sub = 1'b0;
        restart(8'h05);
        run(2100, 1'b1, 1'b1);
        chk(w_first, 2048, "R4 main/128 first fast pulse");
        chk(w_n, 1, "R4 sub strobe ignored");
        src_sub = 1'b1;
        restart(8'h05);
        run(40, 1'b1, 1'b0);
        chk(w_n, 0, "R4 main strobe ignored on sub source");
    endtask

    task automatic t_fast();
        restart(8'h05);
        run(160, 1'b0, 1'b1);
        chk(w_first, 16, "R7 fast first pulse");
        chk(w_n, 5, "R7 fast pulse count");
        chk(w_last, 144, "R7 fast last pulse");
    endtask

    task automatic t_presc_stop();
        restart(8'h01);
        run(200, 1'b0, 1'b1);
        chk(w_n, 0, "R5 stopped prescaler no watch");
        restart(8'h05);
        run(10, 1'b0, 1'b1);
        restart(8'h05);
        run(40, 1'b0, 1'b1);
        chk(w_first, 16, "R5 restart from zero");
    endtask

    task automatic t_normal_long();
        restart(8'h06);
        run(24600, 1'b0, 1'b1);
        chk(w_first, 8192, "R8 long first pulse");
        chk(w_last, 24576, "R8 long second pulse");
        chk(w_n, 2, "R8 long count");
    endtask

    task automatic t_normal_short();
        restart(8'h0E);
        run(12300, 1'b0, 1'b1);
        chk(w_first, 4096, "R9 short first pulse");
        chk(w_last, 12288, "R9 short second pulse");
        chk(w_n, 2, "R9 short count");
    endtask

    task automatic t_intervals();
        for (int c = 0; c < 6; c++) begin
            int h;
            h = 1 << (c + 3);
            restart(8'(c << 4) | 8'h04);
            run(8 * h, 1'b0, 1'b1);
            chk(i_first, h, $sformatf("R10 code %0d first", c));
            chk(i_last, 7 * h, $sformatf("R10 code %0d last", c));
            chk(i_n, 4, $sformatf("R10 code %0d count", c));
        end
    endtask

    task automatic t_bad_codes();
        for (int c = 6; c < 8; c++) begin
            restart(8'(c << 4) | 8'h04);
            run(1100, 1'b0, 1'b1);
            chk(i_n, 0, $sformatf("R11 code %0d silent", c));
        end
    endtask

    task automatic t_counter_stop();
        restart(8'h0C);
        run(5000, 1'b0, 1'b1);
        chk(w_n, 0, "R6 stopped counter no watch");
        wr_bit(1, 1'b1);
        clr_stats();
        run(3800, 1'b0, 1'b1);
        chk(w_first, (512 - (5000 % 512)) + 7 * 512, "R6 counter starts from zero");
    endtask

    task automatic t_coincide();
        restart(8'h15);
        run(100, 1'b0, 1'b1);
        chk(w_first, 16, "R12 coincident watch first");
        chk(i_first, 16, "R12 coincident intv first");
        chk(both_n, 3, "R12 both high same cycle");
        chk(w_n, 3, "R12 watch count");
        chk(i_n, 3, "R12 intv count");
    endtask

    initial begin
        clr_stats();
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_byte_write();
        t_bit_write();
        t_main_src();
        t_fast();
        t_presc_stop();
        t_normal_long();
        t_normal_short();
        t_intervals();
        t_bad_codes();
        t_counter_stop();
        t_coincide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG && !done) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule